// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Processor

This block is a 32-bit processor that completes one instruction per clock. It fetches a word from a private instruction store at the current program counter and decodes it. It reads up to two source registers, runs the ALU, optionally touches a private data store, writes back at most one register and then picks the next program counter. The supported set is register-register add, sub, and, or and set-less-than; add-immediate; load word; store word; branch-if-equal; and an absolute jump.

Both stores are plain word arrays. The environment fills them through two simple write ports while reset is held. Once reset is released the core runs from address 0. The only visible results are the program counter and a write-back debug strobe, which carries the register number and value of every register update as it happens.

The decoder first maps each opcode onto an instruction kind: NOP, ALU, ADDI, LOAD, STORE, BRANCH or JUMP. A second process turns the kind into the control word. There is no multi-cycle state: every kind finishes in the cycle it is fetched. From every kind the transition is to the next fetch, either sequential or redirected.

Top module: `cpu_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), `pc_o` is 0, `wb_en` is 0, and every general register reads 0 once reset is released.
- R2: An instruction is fetched from word `pc_o[..:2]` of the instruction store. Unless it is a taken branch or a jump, the next `pc_o` is `pc_o + 4`.
- R3: Opcode 0x00 with funct 0x20/0x22/0x24/0x25 writes rs+rt, rs−rt, rs&rt or rs|rt into rd. The fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11.
- R4: Opcode 0x00 with funct 0x2A writes 1 into rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 0x08 writes rs plus the sign-extended bits 15:0 into rt.
- R6: Opcode 0x23 writes into rt the data word at byte address rs + sign-extended bits 15:0. Words written through the data load port are readable this way.
- R7: Opcode 0x2B stores rt at byte address rs + sign-extended bits 15:0. A later load from that address returns it.
- R8: Opcode 0x04 with rs == rt sets the next `pc_o` to `pc_o + 4 + (sext(imm) << 2)`. With rs != rt, the next `pc_o` is `pc_o + 4`.
- R9: Opcode 0x02 sets the next `pc_o` to `{(pc_o+4)[31:28], bits 25:0, 2'b00}`.
- R10: Register 0 always reads 0. An instruction targeting it produces no write (`wb_en` stays 0).
- R11: Any other opcode, or opcode 0x00 with any other funct, changes no register or memory and advances `pc_o` by 4.
- R12: `wb_en` is high exactly in the cycle whose instruction updates a nonzero register. In that cycle `wb_addr`/`wb_data` give the register number and the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write strobe |
| imem_waddr | input | $clog2(IMEM_WORDS) | Instruction store word index |
| imem_wdata | input | 32 | Instruction word to store |
| dmem_we | input | 1 | Data store write strobe (load port) |
| dmem_waddr | input | $clog2(DMEM_WORDS) | Data store word index |
| dmem_wdata | input | 32 | Data word to store |
| pc_o | output | 32 | Current program counter |
| wb_en | output | 1 | Register update happens this cycle |
| wb_addr | output | 5 | Register being updated |
| wb_data | output | 32 | Value being written |

## Verification
The bench builds the core with the default 64-word instruction and data stores. That size fits a program of about thirty instructions, including a three-pass backward-branch loop. It also lets a store and load use a negative offset from a base of 64, landing on data word 15, so the sign extension of the memory offset is exercised. The program also covers signed set-less-than in both directions, writes aimed at register 0, an unknown opcode, an unknown funct, an untaken branch, and a load of a word placed through the data load port.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_JMP   = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_ALU,
        K_ADDI,
        K_LOAD,
        K_STORE,
        K_BRANCH,
        K_JUMP
    } ikind_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    use_imm;
        logic    mem_to_reg;
        logic    mem_we;
        logic    is_beq;
        logic    is_jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    output logic [W-1:0]            rd1,
    output logic [W-1:0]            rd2,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd
);
    logic [W-1:0]    regs [NREG];
    logic [NREG-1:0] load;

    // one load strobe per register; register 0 never loads
    always_comb begin
        load = '0;
        if (we) load[wa] = 1'b1;
        load[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 1; i < NREG; i++)
                if (load[i]) regs[i] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ikind_e     kind,
    output ctrl_t      ctrl
);
    alu_op_e fn_op;
    logic    fn_ok;

    always_comb begin
        fn_ok = 1'b1;
        unique case (funct)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            FN_SLT:  fn_op = ALU_SLT;
            default: begin fn_op = ALU_ADD; fn_ok = 1'b0; end
        endcase
    end

    // opcode -> instruction kind
    always_comb begin
        unique case (opcode)
            OPC_REG:   kind = fn_ok ? K_ALU : K_NOP;
            OPC_ADDI:  kind = K_ADDI;
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_BEQ:   kind = K_BRANCH;
            OPC_JMP:   kind = K_JUMP;
            default:   kind = K_NOP;
        endcase
    end

    // kind -> control word
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, mem_to_reg: 1'b0,
                 mem_we: 1'b0, is_beq: 1'b0, is_jump: 1'b0, alu_op: ALU_ADD};
        unique case (kind)
            K_ALU:    begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = fn_op; end
            K_ADDI:   begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
            K_LOAD:   begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_to_reg = 1'b1; end
            K_STORE:  begin ctrl.use_imm = 1'b1; ctrl.mem_we = 1'b1; end
            K_BRANCH: begin ctrl.is_beq = 1'b1; ctrl.alu_op = ALU_SUB; end
            K_JUMP:   ctrl.is_jump = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          imem_we,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_waddr,
    input  logic [31:0]                   imem_wdata,
    input  logic                          dmem_we,
    input  logic [$clog2(DMEM_WORDS)-1:0] dmem_waddr,
    input  logic [31:0]                   dmem_wdata,
    output logic [31:0]                   pc_o,
    output logic                          wb_en,
    output logic [4:0]                    wb_addr,
    output logic [31:0]                   wb_data
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [31:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y, load_val;
    logic        alu_zero, rf_we;
    logic [4:0]  dst;
    ikind_e      kind;
    ctrl_t       ctrl;
    logic        unused_shamt;

    always_ff @(posedge clk)
        if (imem_we) imem[imem_waddr] <= imem_wdata;

    assign instr        = imem[pc_q[IAW+1:2]];
    assign imm_sx       = {{16{instr[15]}}, instr[15:0]};
    assign unused_shamt = ^instr[10:6];

    cpu_decode u_dec (
        .opcode(instr[31:26]),
        .funct (instr[5:0]),
        .kind  (kind),
        .ctrl  (ctrl)
    );

    assign dst   = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign rf_we = ctrl.reg_we && !rst;

    cpu_regfile #(.NREG(32), .W(32)) u_rf (
        .clk(clk), .rst(rst),
        .ra1(instr[25:21]), .ra2(instr[20:16]),
        .rd1(rs_val), .rd2(rt_val),
        .we(rf_we), .wa(dst), .wd(wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

    cpu_alu #(.W(32)) u_alu (
        .a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero)
    );

    assign load_val = dmem[alu_y[DAW+1:2]];

    always_ff @(posedge clk) begin
        if (dmem_we)                   dmem[dmem_waddr]    <= dmem_wdata;
        else if (!rst && ctrl.mem_we)  dmem[alu_y[DAW+1:2]] <= rt_val;
    end

    assign wb_data = ctrl.mem_to_reg ? load_val : alu_y;
    assign wb_addr = dst;
    assign wb_en   = rf_we && (dst != 5'd0);

    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.is_jump)                  pc_next = jmp_tgt;
        else if (ctrl.is_beq && alu_zero)  pc_next = br_tgt;
        else                               pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        wb_en,
    input logic [31:0] wb_data
);
    logic [31:0] c_plus4, c_jump, c_branch;
    assign c_plus4  = pc_o + 32'd4;
    assign c_jump   = {c_plus4[31:28], instr[25:0], 2'b00};
    assign c_branch = c_plus4 + {{14{instr[15]}}, instr[15:0], 2'b00};

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_o == 32'd0);

    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr[31:26]) != 6'h04 && $past(instr[31:26]) != 6'h02)
        |-> pc_o == $past(c_plus4));

    assert_slt_bool_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_en && instr[31:26] == 6'h00 && instr[5:0] == 6'h2A) |-> wb_data[31:1] == 31'd0);

    assert_beq_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr[31:26]) == 6'h04 && $past(rs_val) == $past(rt_val))
        |-> pc_o == $past(c_branch));

    assert_beq_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr[31:26]) == 6'h04 && $past(rs_val) != $past(rt_val))
        |-> pc_o == $past(c_plus4));

    assert_jump_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr[31:26]) == 6'h02) |-> pc_o == $past(c_jump));

    assert_zero_reg_R10: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> rs_val == 32'd0);
endmodule

bind cpu_core cpu_core_chk u_chk (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .wb_en(wb_en), .wb_data(wb_data)
);

// File: tb/tb_cpu_core.sv
module tb_cpu_core;
    localparam int IW = 64;
    localparam int DW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [5:0]  dmem_waddr = '0;
    logic [31:0] dmem_wdata = '0;
    logic [31:0] pc_o;
    logic        wb_en;
    logic [4:0]  wb_addr;
    logic [31:0] wb_data;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cpu_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut (
        .clk(clk), .rst(rst),
        .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .pc_o(pc_o), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // behavioural reference state
    logic [31:0] prog [IW];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [DW];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int word_idx);
        return {6'h02, 26'(word_idx)};
    endfunction

    function automatic string tag_of(logic [31:0] ins);
        case (ins[31:26])
            6'h00: begin
                if (ins[5:0] == 6'h2A) return "R4";
                if (ins[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25})
                    return (ins[15:11] == 0) ? "R10" : "R3";
                return "R11";
            end
            6'h08: return (ins[20:16] == 0) ? "R10" : "R5";
            6'h23: return "R6";
            6'h2B: return "R7";
            6'h04: return "R8";
            6'h02: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // compare the current cycle, then advance the model
    task automatic compare_and_step();
        logic [31:0] ins, a, b, se, res, npc, p4;
        logic        wr;
        int          dst;
        string       tg;
        ins = prog[m_pc[7:2]];
        tg  = tag_of(ins);
        a   = (ins[25:21] == 0) ? 32'd0 : m_reg[ins[25:21]];
        b   = (ins[20:16] == 0) ? 32'd0 : m_reg[ins[20:16]];
        se  = {{16{ins[15]}}, ins[15:0]};
        p4  = m_pc + 4;
        npc = p4;
        wr  = 1'b0; dst = 0; res = '0;
        case (ins[31:26])
            6'h00: begin
                dst = ins[15:11]; wr = 1'b1;
                case (ins[5:0])
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: wr = 1'b0;
                endcase
            end
            6'h08: begin dst = ins[20:16]; wr = 1'b1; res = a + se; end
            6'h23: begin dst = ins[20:16]; wr = 1'b1; res = m_mem[(a + se) / 4 % DW]; end
            6'h2B: m_mem[(a + se) / 4 % DW] = b;
            6'h04: if (a == b) npc = p4 + (se << 2);
            6'h02: npc = {p4[31:28], ins[25:0], 2'b00};
            default: ;
        endcase
        if (dst == 0) wr = 1'b0;
        check(tg, "R2 pc", pc_o, m_pc);
        check(tg, "R12 wb_en", {31'd0, wb_en}, {31'd0, wr});
        if (wr) begin
            check(tg, "R12 wb_addr", {27'd0, wb_addr}, 32'(dst));
            check(tg, "R12 wb_data", wb_data, res);
            m_reg[dst] = res;
        end
        m_pc = npc;
    endtask

    initial begin
        int n = 0;
        for (int i = 0; i < IW; i++) prog[i] = 32'hFC00_0000; // unknown opcode filler
        prog[n++] = enc_i(6'h08, 0, 1, 5);            // r1 = 5
        prog[n++] = enc_i(6'h08, 0, 2, -3);           // r2 = -3
        prog[n++] = enc_r(1, 2, 3, 6'h20);            // add
        prog[n++] = enc_r(2, 1, 4, 6'h22);            // sub -> -8
        prog[n++] = enc_r(1, 2, 5, 6'h24);            // and
        prog[n++] = enc_r(1, 2, 6, 6'h25);            // or
        prog[n++] = enc_r(2, 1, 7, 6'h2A);            // slt -3<5 -> 1
        prog[n++] = enc_r(1, 2, 8, 6'h2A);            // slt 5<-3 -> 0
        prog[n++] = enc_i(6'h08, 0, 0, 7);            // write to r0 ignored
        prog[n++] = enc_r(0, 20, 9, 6'h20);           // r0 + untouched r20 = 0 (R1, R10)
        prog[n++] = enc_i(6'h08, 0, 10, 64);          // base 64
        prog[n++] = enc_i(6'h2B, 10, 4, -4);          // store r4 to word 15
        prog[n++] = enc_i(6'h23, 10, 11, -4);         // load it back
        prog[n++] = 32'hFC00_0000;                    // unknown opcode
        prog[n++] = enc_r(1, 2, 12, 6'h00);           // unknown funct
        prog[n++] = enc_i(6'h04, 1, 2, 5);            // beq not taken
        prog[n++] = enc_i(6'h08, 0, 12, 3);           // loop count
        prog[n++] = enc_i(6'h08, 12, 12, -1);         // word 17: decrement
        prog[n++] = enc_i(6'h04, 12, 0, 1);           // exit to 20
        prog[n++] = enc_j(17);                        // back
        prog[n++] = enc_i(6'h04, 0, 0, 2);            // word 20: to 23
        prog[n++] = enc_i(6'h08, 0, 13, 1);           // skipped
        prog[n++] = enc_i(6'h08, 0, 13, 2);           // skipped
        prog[n++] = enc_i(6'h2B, 0, 1, 0);            // store r1 at word 0
        prog[n++] = enc_i(6'h23, 0, 14, 0);           // load word 0
        prog[n++] = enc_i(6'h23, 0, 15, 16);          // preloaded word 4
        prog[n++] = enc_i(6'h08, 15, 16, -32768);     // most negative immediate
        prog[n++] = enc_j(n);                         // park

        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < DW; i++) m_mem[i] = '0;
        m_mem[4] = 32'hCAFE_0123;
        m_pc = '0;

        rst = 1'b1;
        for (int i = 0; i < IW; i++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        dmem_we = 1'b1; dmem_waddr = 6'd4; dmem_wdata = 32'hCAFE_0123;
        @(negedge clk);
        dmem_we = 1'b0;
        @(negedge clk);
        check("R1", "reset pc", pc_o, 32'd0);
        check("R1", "reset wb_en", {31'd0, wb_en}, 32'd0);
        rst = 1'b0;
        for (int c = 0; c < 60; c++) begin
            #1;
            compare_and_step();
            @(negedge clk);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule